// File: doc/BRIEF.md
# Ripple-Carry Slice ALU

This block is a purely combinational arithmetic-logic unit. It is built from a row of identical one-bit cells, and the carry moves from each cell to the next. Each cell combines one bit of operand X with one bit of operand Y. Before the cell uses the Y bit, an invert line can complement it. The cell then gives out one of four things: the bitwise AND, the bitwise OR, the full-adder sum, or a constant zero.

Subtraction has no code of its own. To form X minus Y, the caller sets the invert line and drives the carry seed into the lowest cell high. The row then computes X plus the complement of Y plus one, which is the two's-complement difference. With the invert line and the carry seed both low, the same row adds.

The block holds no state. The caller drives operands and controls and reads the result in the same cycle. No clock, reset or handshake is involved.

Top module: `ripple_alu`

## Requirements
- R1: With `func_sel` = 0, `alu_out` is the bitwise AND of `opnd_x` and the effective Y operand. The effective Y operand is `~opnd_y` when `y_negate` is 1 and `opnd_y` otherwise.
- R2: With `func_sel` = 1, `alu_out` is the bitwise OR of `opnd_x` and the effective Y operand.
- R3: With `func_sel` = 2, `alu_out` is the low WIDTH bits of `opnd_x` + effective Y + `carry_seed`.
- R4: With `func_sel` = 3, `alu_out` is all zeros, whatever the operands and the other controls are.
- R5: `carry_top` is bit WIDTH of `opnd_x` + effective Y + `carry_seed`, for every value of `func_sel`.
- R6: With `y_negate` = 1, `carry_seed` = 1 and `func_sel` = 2, `alu_out` equals `opnd_x` - `opnd_y` modulo 2^WIDTH. In this mode `carry_top` is 1 exactly when `opnd_x` >= `opnd_y` as unsigned numbers.
- R7: With `y_negate` = 0, `carry_seed` = 0 and `func_sel` = 2, `alu_out` equals `opnd_x` + `opnd_y` modulo 2^WIDTH. In this mode `carry_top` is 1 exactly when the unsigned sum overflows.
- R8: A carry that enters at bit 0 travels through every cell. For example, X = all ones, Y = 0 and seed = 1 give a zero result with `carry_top` = 1.
- R9: The outputs follow a change on any input without any clock edge. The block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | WIDTH (32) | First operand |
| opnd_y | input | WIDTH (32) | Second operand, before optional inversion |
| func_sel | input | 2 | Cell output select: 0 AND, 1 OR, 2 sum, 3 zero |
| y_negate | input | 1 | Complement every Y bit before use |
| carry_seed | input | 1 | Carry into the lowest cell |
| alu_out | output | WIDTH (32) | Result |
| carry_top | output | 1 | Carry out of the highest cell |

## Verification
The hardest case to reach is a carry or borrow that runs the full length of the row. Uniformly random operands seldom line up a long run of propagating bits, so they almost never exercise it. The stimulus therefore mixes directed vectors (all ones plus seed, equal operands under subtraction, operands that differ by one) with random vectors shaped so that Y is near X or near the complement of X. Every vector is applied under each of the four select values and each of the four invert and seed combinations. Each vector is compared with a behavioural sum.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
  typedef enum logic [1:0] {
    FN_AND   = 2'd0,
    FN_OR    = 2'd1,
    FN_SUM   = 2'd2,
    FN_CLEAR = 2'd3
  } fn_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import ralu_pkg::*;
(
  input  logic x_bit,
  input  logic y_bit,
  input  logic neg_y,
  input  logic c_in,
  input  fn_e  fn,
  output logic q_bit,
  output logic c_out
);
  logic y_use;
  logic and_t;
  logic or_t;
  logic sum_t;

  assign y_use = neg_y ? ~y_bit : y_bit;
  assign and_t = x_bit & y_use;
  assign or_t  = x_bit | y_use;
  assign sum_t = x_bit ^ y_use ^ c_in;
  assign c_out = (x_bit & y_use) | (c_in & (x_bit | y_use));

  always_comb begin
    unique case (fn)
      FN_AND:  q_bit = and_t;
      FN_OR:   q_bit = or_t;
      FN_SUM:  q_bit = sum_t;
      default: q_bit = 1'b0;
    endcase
  end

  // Weighted cell outputs must equal the count of ones among the three adder inputs.
  always_comb begin
    if (fn == FN_SUM) begin
      AST_SLICE_COUNT: assert ({c_out, q_bit} == 2'($countones({x_bit, y_use, c_in}))) // R3
        else $error("cell sum/carry inconsistent");
    end
  end
endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import ralu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] xv,
  input  logic [WIDTH-1:0] yv,
  input  logic             neg_y,
  input  logic             c_seed,
  input  fn_e              fn,
  output logic [WIDTH-1:0] qv,
  output logic             c_last
);
  localparam int NCARRY = WIDTH + 1;

  logic [NCARRY-1:0] cc;
  assign cc[0] = c_seed;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    alu_bit_slice u_cell (
      .x_bit (xv[i]),
      .y_bit (yv[i]),
      .neg_y (neg_y),
      .c_in  (cc[i]),
      .fn    (fn),
      .q_bit (qv[i]),
      .c_out (cc[i+1])
    );
  end

  assign c_last = cc[WIDTH];

  // Whole row against an arithmetic sum: the carry chain must link cell i to cell i+1.
  always_comb begin
    AST_CHAIN_CARRY: assert (c_last == 1'({1'b0, xv} + {1'b0, (neg_y ? ~yv : yv)} + NCARRY'(c_seed) >> WIDTH)) // R5
      else $error("carry chain broken");
  end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import ralu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [1:0]       func_sel,
  input  logic             y_negate,
  input  logic             carry_seed,
  output logic [WIDTH-1:0] alu_out,
  output logic             carry_top
);
  fn_e fn;
  assign fn = fn_e'(func_sel);

  alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
    .xv     (opnd_x),
    .yv     (opnd_y),
    .neg_y  (y_negate),
    .c_seed (carry_seed),
    .fn     (fn),
    .qv     (alu_out),
    .c_last (carry_top)
  );

  always_comb begin
    if (func_sel == 2'd3) begin
      AST_CLEAR_ZERO: assert (alu_out == '0) // R4
        else $error("clear select not zero");
    end
    if (func_sel == 2'd0 && !y_negate) begin
      AST_AND_PLAIN: assert (alu_out == (opnd_x & opnd_y)) // R1
        else $error("AND mismatch");
    end
    if (func_sel == 2'd1 && !y_negate) begin
      AST_OR_PLAIN: assert (alu_out == (opnd_x | opnd_y)) // R2
        else $error("OR mismatch");
    end
    if (func_sel == 2'd2 && y_negate && carry_seed) begin
      AST_SUB_DIFF: assert (alu_out == opnd_x - opnd_y && carry_top == (opnd_x >= opnd_y)) // R6
        else $error("subtract mismatch");
    end
    if (func_sel == 2'd2 && !y_negate && !carry_seed) begin
      AST_ADD_SUM: assert (alu_out == opnd_x + opnd_y) // R7
        else $error("add mismatch");
    end
  end
endmodule

// File: tb/ripple_alu_tb.sv
module ripple_alu_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] ax = '0;
  logic [W-1:0] by = '0;
  logic [1:0]   fsel = 2'd0;
  logic         neg = 1'b0;
  logic         seed = 1'b0;
  logic [W-1:0] res;
  logic         cout;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ripple_alu #(.WIDTH(W)) u_dut (
    .opnd_x     (ax),
    .opnd_y     (by),
    .func_sel   (fsel),
    .y_negate   (neg),
    .carry_seed (seed),
    .alu_out    (res),
    .carry_top  (cout)
  );

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [1:0] f, input logic n, input logic c);
    logic [W-1:0] be;
    logic [W:0]   s;
    logic [W-1:0] r;
    be = n ? ~b : b;
    s  = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, c};
    case (f)
      2'd0:    r = a & be;
      2'd1:    r = a | be;
      2'd2:    r = s[W-1:0];
      default: r = '0;
    endcase
    return {s[W], r};
  endfunction

  function automatic string tag_of(input logic [1:0] f);
    case (f)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [W:0] e;
    e = model(ax, by, fsel, neg, seed);
    n_vec++;
    if (res !== e[W-1:0]) begin
      n_bad++;
      $display("FAIL %s result a=%h b=%h f=%0d n=%0b c=%0b got %h exp %h",
               tag, ax, by, fsel, neg, seed, res, e[W-1:0]);
    end
    if (cout !== e[W]) begin
      n_bad++;
      $display("FAIL R5 carry a=%h b=%h f=%0d got %0b exp %0b", ax, by, fsel, cout, e[W]);
    end
    if (fsel == 2'd2 && neg && seed) begin
      // R6: borrow-free subtraction leaves carry high exactly when x >= y
      if (res !== ax - by || cout !== (ax >= by)) begin
        n_bad++;
        $display("FAIL R6 sub a=%h b=%h got %h/%0b exp %h/%0b", ax, by, res, cout, ax - by, ax >= by);
      end
    end
    if (fsel == 2'd2 && !neg && !seed) begin
      // R7: unsigned overflow appears on carry
      if (res !== ax + by || cout !== (({1'b0, ax} + {1'b0, by}) >> W)) begin
        n_bad++;
        $display("FAIL R7 add a=%h b=%h got %h/%0b", ax, by, res, cout);
      end
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] f, input logic n, input logic c, input string tag);
    @(posedge clk);
    ax = a; by = b; fsel = f; neg = n; seed = c;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic sweep(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int f = 0; f < 4; f++)
      for (int m = 0; m < 4; m++)
        apply(a, b, 2'(f), m[1], m[0], tag_of(2'(f)));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // all-zero inputs: AND select gives zero, no carry (R1)
    @(negedge clk);
    compare("R1");

    // R8: carry seed runs through every cell
    apply('1, '0, 2'd2, 1'b0, 1'b1, "R8");
    apply(32'h0000_0001, '1, 2'd2, 1'b0, 1'b0, "R8");
    // R6: equal operands, operand one larger / smaller
    apply(32'h1234_5678, 32'h1234_5678, 2'd2, 1'b1, 1'b1, "R6");
    apply(32'h0000_0000, 32'h0000_0001, 2'd2, 1'b1, 1'b1, "R6");
    apply(32'h8000_0000, 32'h7fff_ffff, 2'd2, 1'b1, 1'b1, "R6");
    // R7: overflow at top bit
    apply(32'h8000_0000, 32'h8000_0000, 2'd2, 1'b0, 1'b0, "R7");
    // R4: clear select with busy operands
    apply('1, '1, 2'd3, 1'b1, 1'b1, "R4");

    // R9: no clock edge needed for outputs to follow inputs
    @(negedge clk);
    #1 ax = 32'h00ff_00ff; by = 32'h0f0f_0f0f; fsel = 2'd1; neg = 1'b0; seed = 1'b0;
    #1 compare("R9");
    #1 fsel = 2'd2; neg = 1'b1; seed = 1'b1;
    #1 compare("R9");

    sweep('0, '0);
    sweep('1, '1);
    sweep(32'haaaa_aaaa, 32'h5555_5555);

    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = $urandom;
      case (k % 4)
        0: b = $urandom;
        1: b = a;
        2: b = ~a ^ (32'h1 << (k % W));
        default: b = a + 32'($urandom % 3) - 32'd1;
      endcase
      sweep(a, b);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule